// File: doc/BRIEF.md
# I2C Master Interrupt Register Set

This block holds the interrupt state of an I2C master controller. Twelve event inputs, one per interrupt source, set bits in a raw status register. A software-written enable register selects which raw bits appear in the masked status register and drive the single interrupt line. Ten of the sources are sticky. Each of them can be cleared alone by reading its own clear address, or together with the others by reading one shared clear address. The receive-threshold and transmit-threshold sources are level conditions: they follow their inputs, and no read clears them.

A separate abort-cause register collects which transmit-abort reasons have occurred. Any valid cause also raises the transmit-abort status bit. The cause register is cleared only by a read of the transmit-abort clear address. A read of the shared clear address leaves it unchanged, so software can still see why a transfer failed.

The bus is a single-cycle addressed port. Read data is combinational from the current state. A read's clearing side effect takes hold at the clock edge that ends the access, so the read returns the value from before the clear.

Top module: `i2c_irq_regs`

## Requirements
- R1: A high cycle on `evt_i[k]` for a sticky source k (every k except 2 and 4) sets raw bit k from the next cycle on. The bit stays set until it is cleared. The raw status reads at byte address 0x08, bits [11:0]. The bit order is 0 rx underflow, 1 rx overflow, 2 rx threshold, 3 tx overflow, 4 tx threshold, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call.
- R2: Raw bits 2 and 4 equal the value that `evt_i[2]` and `evt_i[4]` had one cycle earlier. No clear read changes them.
- R3: The enable register at 0x04 (bits [11:0]) is written by a bus write and reads back unchanged. The masked status at 0x00 reads as raw status AND enable.
- R4: `irq_o` is high exactly when the masked status is nonzero.
- R5: A read of address 0x40 + 4*k clears only sticky raw bit k, from the next cycle on. It returns that bit's value before the clear in bit 0. For k = 2 or 4 the read returns the bit and clears nothing.
- R6: A read of 0x10 clears every sticky raw bit and leaves bits 2 and 4 unchanged. It returns in bit 0 the OR of the sticky raw bits before the clear.
- R7: When a source's event and a clear read of that source fall in the same cycle, the bit ends up set.
- R8: The abort-cause register at 0x0C ORs in `abrt_cause_i` through the valid-cause mask 0x1EBF, so bits 6, 8 and 15:13 always read 0. Any valid cause bit also sets raw bit 6 in the next cycle.
- R9: The abort-cause register is cleared only by a read of 0x58, the tx-abort clear address. A cause arriving in that same cycle is kept. A read of 0x10 leaves the register unchanged.
- R10: A write to any address other than 0x04 changes no state. A read of any address other than the clear addresses changes no state. Unmapped addresses read 0.
- R11: After reset the raw status, the enable register, the abort-cause register and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 12 | Per-source event inputs (pulse for sticky sources, level for bits 2 and 4) |
| abrt_cause_i | input | 13 | Transmit-abort reason bits, one per cause |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request, OR of masked status |

## Verification
The bench builds the block with its default 8-bit address and 32-bit data. With these widths the whole map can be reached: the five fixed registers, all twelve per-source clear addresses, and unmapped holes that random addresses hit. A 32-bit read word carries the full abort-cause field, including the bits the valid-cause mask forces to zero. Random events and causes are sparse, so bits stay set long enough for clear reads to find them. Directed cases force a clear and an event into the same cycle, and they check the shared clear against the abort-cause register.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    // Source count and order are fixed by the status bit layout.
    localparam int NUM_SRC      = 12;
    localparam int CAUSE_W      = 13;
    localparam int IDX_TX_ABRT  = 6;

    // Sources that track an input level instead of latching.
    localparam logic [NUM_SRC-1:0] LEVEL_SRCS  = 12'h014;
    localparam logic [NUM_SRC-1:0] STICKY_SRCS = ~LEVEL_SRCS;

    // Abort reasons that exist; the others read zero.
    localparam logic [CAUSE_W-1:0] CAUSE_VALID = 13'h1EBF;

    // Byte offsets of the register map.
    localparam int OFS_STAT     = 'h00;
    localparam int OFS_MASK     = 'h04;
    localparam int OFS_RAW      = 'h08;
    localparam int OFS_CAUSE    = 'h0C;
    localparam int OFS_CLR_ALL  = 'h10;
    localparam int OFS_CLR_BASE = 'h40;
    localparam int OFS_STRIDE   = 4;

    typedef struct packed {
        logic               stat;
        logic               mask;
        logic               raw;
        logic               cause;
        logic               clr_all;
        logic [NUM_SRC-1:0] clr_src;
    } hit_t;

endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output hit_t              hit,
    output logic [NUM_SRC-1:0] clr_vec,
    output logic              clr_cause,
    output logic              mask_we
);

    logic rd;

    always_comb begin
        hit         = '0;
        hit.stat    = (bus_addr == ADDR_W'(OFS_STAT));
        hit.mask    = (bus_addr == ADDR_W'(OFS_MASK));
        hit.raw     = (bus_addr == ADDR_W'(OFS_RAW));
        hit.cause   = (bus_addr == ADDR_W'(OFS_CAUSE));
        hit.clr_all = (bus_addr == ADDR_W'(OFS_CLR_ALL));
        for (int i = 0; i < NUM_SRC; i++) begin
            hit.clr_src[i] = (bus_addr == ADDR_W'(OFS_CLR_BASE + OFS_STRIDE * i));
        end
    end

    assign rd        = bus_sel && !bus_wr;
    assign clr_vec   = rd ? ((hit.clr_src | {NUM_SRC{hit.clr_all}}) & STICKY_SRCS) : '0;
    assign clr_cause = rd && hit.clr_src[IDX_TX_ABRT];
    assign mask_we   = bus_sel && bus_wr && hit.mask;

endmodule

// File: rtl/i2c_irq_srcbank.sv
module i2c_irq_srcbank
    import i2c_irq_pkg::*;
#(
    parameter logic [NUM_SRC-1:0] LEVEL = LEVEL_SRCS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] raw_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] raw;
    } st_t;

    st_t                st_d, st_q;
    logic [NUM_SRC-1:0] raw_nx;
    logic               unused_clr;

    assign unused_clr = ^(clr_i & LEVEL);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        if (LEVEL[g]) begin : g_level
            assign raw_nx[g] = set_i[g];
        end else begin : g_sticky
            // set has priority over a same-cycle clear
            assign raw_nx[g] = set_i[g] | (st_q.raw[g] & ~clr_i[g]);
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.raw = raw_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o = st_q.raw;

endmodule

// File: rtl/i2c_irq_abort.sv
module i2c_irq_abort
    import i2c_irq_pkg::*;
#(
    parameter logic [CAUSE_W-1:0] VALID = CAUSE_VALID
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               clr_i,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               any_o
);

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
    } st_t;

    st_t                st_d, st_q;
    logic [CAUSE_W-1:0] fresh;

    assign fresh = cause_i & VALID;

    always_comb begin
        st_d       = st_q;
        st_d.cause = (clr_i ? '0 : st_q.cause) | fresh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;
    assign any_o   = |fresh;

endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [CAUSE_W-1:0] abrt_cause_i,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);

    localparam logic [NUM_SRC-1:0] ABRT_BIT = NUM_SRC'(1) << IDX_TX_ABRT;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
    } st_t;

    st_t                st_d, st_q;
    hit_t               hit;
    logic [NUM_SRC-1:0] clr_src;
    logic               clr_abrt;
    logic               mask_we;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [CAUSE_W-1:0] abrt_q;
    logic               cause_any;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_SRC];

    i2c_irq_decode #(.ADDR_W(ADDR_W)) i_decode (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .hit       (hit),
        .clr_vec   (clr_src),
        .clr_cause (clr_abrt),
        .mask_we   (mask_we)
    );

    assign set_vec = evt_i | (cause_any ? ABRT_BIT : '0);

    i2c_irq_srcbank #(.LEVEL(LEVEL_SRCS)) i_srcbank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_src),
        .raw_o (raw_q)
    );

    i2c_irq_abort #(.VALID(CAUSE_VALID)) i_abort (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (abrt_cause_i),
        .clr_i   (clr_abrt),
        .cause_o (abrt_q),
        .any_o   (cause_any)
    );

    always_comb begin
        st_d = st_q;
        if (mask_we) st_d.mask = bus_wdata[NUM_SRC-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q = st_q.mask;
    assign irq_o  = |(raw_q & mask_q);

    always_comb begin
        bus_rdata = '0;
        if (hit.stat)         bus_rdata[NUM_SRC-1:0] = raw_q & mask_q;
        else if (hit.mask)    bus_rdata[NUM_SRC-1:0] = mask_q;
        else if (hit.raw)     bus_rdata[NUM_SRC-1:0] = raw_q;
        else if (hit.cause)   bus_rdata[CAUSE_W-1:0] = abrt_q;
        else if (hit.clr_all) bus_rdata[0]           = |(raw_q & STICKY_SRCS);
        else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (hit.clr_src[i]) bus_rdata[0] = raw_q[i];
            end
        end
    end

endmodule

// File: rtl/i2c_irq_chk.sv
module i2c_irq_chk
    import i2c_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [CAUSE_W-1:0] abrt_cause_i,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] raw_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [CAUSE_W-1:0] abrt_q,
    input logic [NUM_SRC-1:0] clr_src,
    input logic               clr_abrt
);

    localparam logic [NUM_SRC-1:0] ABRT_BIT = NUM_SRC'(1) << IDX_TX_ABRT;

    logic [NUM_SRC-1:0] set_now;
    assign set_now = (evt_i | (((abrt_cause_i & CAUSE_VALID) != '0) ? ABRT_BIT : '0))
                     & STICKY_SRCS;

    // R1 / R7: an event always lands, even against a clear
    p_sticky_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((raw_q & $past(set_now)) == $past(set_now)));

    p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((raw_q & LEVEL_SRCS) == ($past(evt_i) & LEVEL_SRCS)));

    p_irq_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);

    p_clear_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((raw_q & $past(clr_src & ~set_now)) == '0));

    p_clear_spares_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(raw_q & ~clr_src) & STICKY_SRCS & ~raw_q) == '0));

    p_cause_sets_abrt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((abrt_cause_i & CAUSE_VALID) != '0) |=> raw_q[IDX_TX_ABRT]);

    p_cause_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_abrt |=> (($past(abrt_q) & ~abrt_q) == '0));

    p_cause_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_abrt && abrt_cause_i == '0) |=> (abrt_q == '0));

endmodule

bind i2c_irq_regs i2c_irq_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt_i),
    .abrt_cause_i (abrt_cause_i),
    .irq_o        (irq_o),
    .raw_q        (raw_q),
    .mask_q       (mask_q),
    .abrt_q       (abrt_q),
    .clr_src      (clr_src),
    .clr_abrt     (clr_abrt)
);

// File: tb/test_i2c_irq_regs.sv
module test_i2c_irq_regs;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [11:0] LVL  = 12'h014;
    localparam logic [11:0] STK  = ~LVL;
    localparam logic [12:0] CVAL = 13'h1EBF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   evt_i = '0;
    logic [12:0]   abrt_cause_i = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [11:0] m_raw = '0, m_mask = '0;
    logic [12:0] m_cause = '0;

    always #5 clk = ~clk;

    i2c_irq_regs #(.ADDR_W(AW), .DATA_W(DW)) i_i2c_irq_regs (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .abrt_cause_i(abrt_cause_i),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int src_of(input logic [7:0] a);
        if (a >= 8'h40 && a < 8'h70 && a[1:0] == 2'b00) return (a - 8'h40) / 4;
        return -1;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        int s;
        s = src_of(a);
        case (a)
            8'h00: return {20'h0, m_raw & m_mask};
            8'h04: return {20'h0, m_mask};
            8'h08: return {20'h0, m_raw};
            8'h0C: return {19'h0, m_cause};
            8'h10: return {31'h0, |(m_raw & STK)};
            default: return (s >= 0) ? {31'h0, m_raw[s]} : 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00, 8'h04: return "R3";
            8'h08:        return "R1";
            8'h0C:        return "R8";
            8'h10:        return "R6";
            default:      return (src_of(a) >= 0) ? "R5" : "R10";
        endcase
    endfunction

    logic [31:0] last_rd;

    // One bus cycle: drive at negedge, check before the edge, then model the edge.
    task automatic cyc(input logic [11:0] ev, input logic [12:0] ca, input bit sel,
                       input bit wr, input logic [7:0] a, input logic [31:0] wd);
        logic [11:0] setv, clr;
        int s;
        @(negedge clk);
        evt_i = ev; abrt_cause_i = ca; bus_sel = sel; bus_wr = wr;
        bus_addr = a; bus_wdata = wd;
        #1;
        last_rd = bus_rdata;
        check(irq_o == |(m_raw & m_mask), "R4", {31'h0, irq_o}, {31'h0, |(m_raw & m_mask)});
        if (sel && !wr) check(bus_rdata == exp_rd(a), tag_of(a), bus_rdata, exp_rd(a));
        @(posedge clk);
        setv = ev | (((ca & CVAL) != 0) ? 12'h040 : 12'h000);
        clr  = '0;
        s    = src_of(a);
        if (sel && !wr) begin
            if (a == 8'h10) clr = STK;
            else if (s >= 0) clr = (12'h1 << s) & STK;
            if (a == 8'h58) m_cause = '0;
        end
        m_raw   = (setv & LVL) | (STK & (setv | (m_raw & ~clr)));
        m_cause = m_cause | (ca & CVAL);
        if (sel && wr && a == 8'h04) m_mask = wd[11:0];
    endtask

    task automatic rd(input logic [7:0] a);
        cyc('0, '0, 1'b1, 1'b0, a, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R11: reset state
        rd(8'h08); check(last_rd == 0, "R11 raw", last_rd, 0);
        rd(8'h04); check(last_rd == 0, "R11 mask", last_rd, 0);
        rd(8'h0C); check(last_rd == 0, "R11 cause", last_rd, 0);
        check(irq_o == 0, "R11 irq", {31'h0, irq_o}, 0);

        // R1 / R3 / R4: set sources 0, 3, 11 with enable on 3
        cyc(12'h809, '0, 1'b1, 1'b1, 8'h04, 32'hFFFF_F008);
        rd(8'h08); check(last_rd == 32'h809, "R1 sticky set", last_rd, 32'h809);
        rd(8'h00); check(last_rd == 32'h008, "R3 masked", last_rd, 32'h008);
        check(irq_o == 1, "R4 irq high", {31'h0, irq_o}, 1);

        // R5: clear source 3 only
        rd(8'h4C); check(last_rd == 1, "R5 pre-clear bit", last_rd, 1);
        rd(8'h08); check(last_rd == 32'h801, "R5 only bit 3 cleared", last_rd, 32'h801);

        // R7: event and its clear together
        cyc(12'h001, '0, 1'b1, 1'b0, 8'h40, '0);
        rd(8'h08); check(last_rd[0] == 1, "R7 set wins", last_rd, 32'h801);

        // R2: level bits hold through clear-all
        cyc(12'h014, '0, 1'b0, 1'b0, 8'h00, '0);
        cyc(12'h014, 13'h0008, 1'b1, 1'b0, 8'h10, '0);
        cyc(12'h014, '0, 1'b1, 1'b0, 8'h08, '0);
        check(last_rd == 32'h054, "R6 clear-all keeps level, cause sets bit 6", last_rd, 32'h054);
        cyc(12'h014, '0, 1'b1, 1'b0, 8'h50, '0);
        cyc(12'h000, '0, 1'b1, 1'b0, 8'h08, '0);
        check(last_rd[4] == 1, "R2 level bit survives its clear read", last_rd, 32'h054);
        rd(8'h08); check(last_rd == 32'h040, "R2 level bits follow input", last_rd, 32'h040);

        // R8: reserved cause bits dropped
        cyc('0, 13'h1FFF, 1'b0, 1'b0, 8'h00, '0);
        rd(8'h0C); check(last_rd == 32'h1EBF, "R8 valid mask", last_rd, 32'h1EBF);

        // R9: clear-all leaves cause, abort clear drops it but keeps a new one
        rd(8'h10);
        rd(8'h0C); check(last_rd == 32'h1EBF, "R9 clear-all keeps cause", last_rd, 32'h1EBF);
        cyc('0, 13'h0004, 1'b1, 1'b0, 8'h58, '0);
        rd(8'h0C); check(last_rd == 32'h0004, "R9 abort clear with new cause", last_rd, 32'h4);

        // R10: writes elsewhere ignored
        cyc('0, '0, 1'b1, 1'b1, 8'h08, 32'hFFFF_FFFF);
        cyc('0, '0, 1'b1, 1'b1, 8'h58, 32'hFFFF_FFFF);
        rd(8'h0C); check(last_rd == 32'h0004, "R10 write to clear addr ignored", last_rd, 32'h4);
        rd(8'h77); check(last_rd == 0, "R10 hole reads zero", last_rd, 0);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] ev;
            logic [12:0] ca;
            logic [7:0]  a;
            int pick;
            ev = 12'($urandom & $urandom & $urandom);
            ca = (($urandom % 8) == 0) ? 13'($urandom & $urandom) : 13'h0;
            pick = $urandom % 20;
            if (pick < 5) a = 8'(pick * 4 + (pick == 4 ? 0 : 0));
            else if (pick < 17) a = 8'(8'h40 + 4 * (pick - 5));
            else a = 8'($urandom);
            cyc(ev, ca, ($urandom % 4) != 0, ($urandom % 5) == 0, a, $urandom);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule